// File: doc/BRIEF.md
# DMA Channel Control Register Unit

This block is the register front end of a single DMA channel. It keeps the channel status word, the command pointer and three condition-select registers. Software changes the status only through a control word whose upper half says which status bits to touch and whose lower half gives their new values. The block then applies the start, pause and stop side effects to the ACTIVE and DEAD flags. It also protects the command pointer from being changed while the channel is busy, and it reports a one-cycle start pulse and a one-cycle descriptor-fetch pulse to the channel sequencer.

The sequencer writes its own status changes (ACTIVE, DEAD, branch-taken, device status and so on) through a separate masked update port. That port wins over a bus write in the same cycle. Three comparators tell the sequencer whether the device-status nibble matches each select register. Descriptor fetch and data movement belong to the sequencer and are not part of this block.

Top module: `chanctl_regs`

## Requirements
- R1: After reset the status word, the command pointer and all three select registers are zero, and `start_o` and `fetch_o` are low.
- R2: A bus write to the control address (word 0) takes the mask from bits 31:16 and the value from bits 15:0. Each status bit whose mask bit is 1 takes the value bit, and each bit whose mask bit is 0 keeps its old value. The new status is visible on the cycle after the write edge.
- R3: Only these bits can be set through the control word: RUN (bit 15), PAUSE (bit 14), FLUSH (bit 13), WAKE (bit 12) and the device-status nibble (bits 3:0). For every other bit the value is taken as zero, so a masked write clears DEAD (bit 11), ACTIVE (bit 10) or branch-taken (bit 8) and never sets them.
- R4: If a control write leaves RUN set, PAUSE clear and DEAD clear, ACTIVE is set and `start_o` is high for exactly one cycle after the write edge. If DEAD is set, ACTIVE stays clear and no start pulse is issued.
- R5: If a control write leaves PAUSE set, ACTIVE is clear afterwards, even when RUN is set.
- R6: A control write that takes RUN from 1 to 0 clears both ACTIVE and DEAD.
- R7: A bus write to the command-pointer address (word 2) while RUN or ACTIVE is set leaves the pointer unchanged and issues no fetch pulse.
- R8: An accepted command-pointer write stores the data with its low 4 bits forced to zero, and `fetch_o` is high for exactly one cycle after the write edge.
- R9: A bus write to the status address (word 1) has no effect on the status.
- R10: When `seq_upd_i` is high, each status bit selected by `seq_mask_i` takes the matching bit of `seq_val_i`. This holds even when a control write lands in the same cycle, in which case unselected bits follow the control write.
- R11: The select registers (interrupt at word 3, branch at word 4, wait at word 5) keep a 4-bit mask in bits 19:16 and a 4-bit value in bits 3:0. Each hit output is high when the device-status nibble and the value agree on every masked bit. A select register of zero always hits.
- R12: Bus reads are combinational. Words 0 and 1 return the status in bits 15:0, word 2 returns the pointer, words 3 to 5 return the select registers with all unkept bits zero, and any other address returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we_i | input | 1 | Bus write strobe |
| bus_addr_i | input | 3 | Word address for reads and writes |
| bus_wdata_i | input | 32 | Bus write data |
| bus_rdata_o | output | 32 | Bus read data (combinational) |
| seq_upd_i | input | 1 | Sequencer status update strobe |
| seq_mask_i | input | 16 | Status bits the sequencer updates |
| seq_val_i | input | 16 | New values for those bits |
| status_o | output | 16 | Current status word |
| cmdptr_o | output | 32 | Current command pointer |
| start_o | output | 1 | One-cycle start request to the sequencer |
| fetch_o | output | 1 | One-cycle descriptor-fetch request |
| int_hit_o | output | 1 | Interrupt-select condition met |
| br_hit_o | output | 1 | Branch-select condition met |
| wait_hit_o | output | 1 | Wait-select condition met |

## Verification
A wrong status bit shows up on `status_o` and on a bus read one edge after the write that caused it. A wrong device-status nibble or select register shows up at once on the three hit outputs, so each side effect is checked by reading the status on the first cycle after its write. A pointer accepted while the channel was busy shows up as a changed `cmdptr_o` and a stray `fetch_o` pulse on the next cycle. A lost start or fetch request shows up as a pulse that is missing on the one cycle where it should appear, so both pulses are sampled on that cycle and again on the cycle after it. Same-cycle collisions between the bus and the sequencer are driven on purpose, because a wrong priority order only becomes visible in that case.

// File: rtl/chanctl_pkg.sv
package chanctl_pkg;
  localparam int ST_W    = 16;
  localparam int DEV_W   = 4;
  localparam int B_RUN   = 15;
  localparam int B_PAUSE = 14;
  localparam int B_FLUSH = 13;
  localparam int B_WAKE  = 12;
  localparam int B_DEAD  = 11;
  localparam int B_ACT   = 10;
  localparam int B_BT    = 8;

  typedef logic [ST_W-1:0] st_t;

  // bits software may drive through the control word
  localparam st_t SW_WRITABLE = st_t'((1 << B_RUN) | (1 << B_PAUSE) | (1 << B_FLUSH) |
                                      (1 << B_WAKE) | ((1 << DEV_W) - 1));

  // word addresses of the register map
  localparam int RA_CTRL = 0;
  localparam int RA_STAT = 1;
  localparam int RA_PTR  = 2;
  localparam int RA_ISEL = 3;
  localparam int RA_BSEL = 4;
  localparam int RA_WSEL = 5;

  function automatic st_t merge_masked(st_t old_v, st_t mask, st_t val);
    return (val & mask) | (old_v & ~mask);
  endfunction

  // control-word merge followed by the run/pause/stop side effects
  function automatic st_t apply_ctrl(st_t old_v, st_t mask, st_t val);
    st_t n;
    n = merge_masked(old_v, mask, val & SW_WRITABLE);
    if (n[B_RUN] && !n[B_PAUSE] && !n[B_DEAD]) n[B_ACT] = 1'b1;
    if (n[B_PAUSE]) n[B_ACT] = 1'b0;
    if (old_v[B_RUN] && !n[B_RUN]) begin
      n[B_ACT]  = 1'b0;
      n[B_DEAD] = 1'b0;
    end
    return n;
  endfunction

  function automatic logic cond_hit(logic [DEV_W-1:0] dev, logic [DEV_W-1:0] m,
                                    logic [DEV_W-1:0] v);
    return ((dev ^ v) & m) == '0;
  endfunction
endpackage

// File: rtl/chanctl_status.sv
module chanctl_status
  import chanctl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ctrl_we,
  input  st_t  ctrl_mask,
  input  st_t  ctrl_val,
  input  logic seq_upd,
  input  st_t  seq_mask,
  input  st_t  seq_val,
  output st_t  status,
  output logic start
);
  st_t  status_q;
  st_t  bus_next;
  st_t  final_next;
  logic start_q;

  always_comb begin
    bus_next   = ctrl_we ? apply_ctrl(status_q, ctrl_mask, ctrl_val) : status_q;
    final_next = seq_upd ? merge_masked(bus_next, seq_mask, seq_val) : bus_next;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q <= '0;
      start_q  <= 1'b0;
    end else begin
      status_q <= final_next;
      start_q  <= ctrl_we && final_next[B_ACT];
    end
  end

  assign status = status_q;
  assign start  = start_q;
endmodule

// File: rtl/chanctl_cmdptr.sv
module chanctl_cmdptr #(
  parameter int PTR_W      = 32,
  parameter int ALIGN_BITS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_req,
  input  logic             busy,
  input  logic [PTR_W-1:0] wdata,
  output logic             wr_ok,
  output logic [PTR_W-1:0] ptr,
  output logic             fetch
);
  localparam logic [PTR_W-1:0] ALIGN_MASK = ~((PTR_W'(1) << ALIGN_BITS) - PTR_W'(1));

  logic [PTR_W-1:0] ptr_q;
  logic             fetch_q;

  assign wr_ok = wr_req && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q   <= '0;
      fetch_q <= 1'b0;
    end else begin
      fetch_q <= wr_ok;
      if (wr_ok) ptr_q <= wdata & ALIGN_MASK;
    end
  end

  assign ptr   = ptr_q;
  assign fetch = fetch_q;
endmodule

// File: rtl/chanctl_sel_bank.sv
module chanctl_sel_bank
  import chanctl_pkg::*;
#(
  parameter int NSEL     = 3,
  parameter int DATA_W   = 32,
  parameter int MASK_LSB = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NSEL-1:0]              we,
  input  logic [DATA_W-1:0]            wdata,
  input  logic [DEV_W-1:0]             devstat,
  output logic [NSEL-1:0][DATA_W-1:0]  rd_word,
  output logic [NSEL-1:0]              hit
);
  for (genvar g = 0; g < NSEL; g++) begin : g_sel
    logic [DEV_W-1:0] m_q;
    logic [DEV_W-1:0] v_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        m_q <= '0;
        v_q <= '0;
      end else if (we[g]) begin
        m_q <= wdata[MASK_LSB +: DEV_W];
        v_q <= wdata[0 +: DEV_W];
      end
    end

    always_comb begin
      rd_word[g]                  = '0;
      rd_word[g][MASK_LSB +: DEV_W] = m_q;
      rd_word[g][0 +: DEV_W]        = v_q;
    end

    assign hit[g] = cond_hit(devstat, m_q, v_q);
  end
endmodule

// File: rtl/chanctl_regs.sv
module chanctl_regs
  import chanctl_pkg::*;
#(
  parameter int ADDR_W     = 3,
  parameter int DATA_W     = 32,
  parameter int ALIGN_BITS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic              seq_upd_i,
  input  logic [ST_W-1:0]   seq_mask_i,
  input  logic [ST_W-1:0]   seq_val_i,
  output logic [ST_W-1:0]   status_o,
  output logic [DATA_W-1:0] cmdptr_o,
  output logic              start_o,
  output logic              fetch_o,
  output logic              int_hit_o,
  output logic              br_hit_o,
  output logic              wait_hit_o
);
  localparam int NSEL     = 3;
  localparam int MASK_LSB = DATA_W / 2;

  // named internal events
  logic                        ctrl_wr;
  logic                        ptr_wr_req;
  logic                        ptr_wr_ok;
  logic                        chan_busy;
  logic [NSEL-1:0]             sel_we;
  logic [NSEL-1:0][DATA_W-1:0] sel_rd;
  logic [NSEL-1:0]             sel_hit;
  st_t                         status;

  assign ctrl_wr    = bus_we_i && (bus_addr_i == ADDR_W'(RA_CTRL));
  assign ptr_wr_req = bus_we_i && (bus_addr_i == ADDR_W'(RA_PTR));
  assign sel_we[0]  = bus_we_i && (bus_addr_i == ADDR_W'(RA_ISEL));
  assign sel_we[1]  = bus_we_i && (bus_addr_i == ADDR_W'(RA_BSEL));
  assign sel_we[2]  = bus_we_i && (bus_addr_i == ADDR_W'(RA_WSEL));
  assign chan_busy  = status[B_RUN] || status[B_ACT];

  chanctl_status i_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl_we   (ctrl_wr),
    .ctrl_mask (bus_wdata_i[MASK_LSB +: ST_W]),
    .ctrl_val  (bus_wdata_i[0 +: ST_W]),
    .seq_upd   (seq_upd_i),
    .seq_mask  (seq_mask_i),
    .seq_val   (seq_val_i),
    .status    (status),
    .start     (start_o)
  );

  chanctl_cmdptr #(
    .PTR_W      (DATA_W),
    .ALIGN_BITS (ALIGN_BITS)
  ) i_cmdptr (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_req (ptr_wr_req),
    .busy   (chan_busy),
    .wdata  (bus_wdata_i),
    .wr_ok  (ptr_wr_ok),
    .ptr    (cmdptr_o),
    .fetch  (fetch_o)
  );

  chanctl_sel_bank #(
    .NSEL     (NSEL),
    .DATA_W   (DATA_W),
    .MASK_LSB (MASK_LSB)
  ) i_sel (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (sel_we),
    .wdata   (bus_wdata_i),
    .devstat (status[DEV_W-1:0]),
    .rd_word (sel_rd),
    .hit     (sel_hit)
  );

  always_comb begin
    bus_rdata_o = '0;
    case (int'(bus_addr_i))
      RA_CTRL, RA_STAT: bus_rdata_o[0 +: ST_W] = status;
      RA_PTR:           bus_rdata_o = cmdptr_o;
      RA_ISEL:          bus_rdata_o = sel_rd[0];
      RA_BSEL:          bus_rdata_o = sel_rd[1];
      RA_WSEL:          bus_rdata_o = sel_rd[2];
      default:          bus_rdata_o = '0;
    endcase
  end

  assign status_o   = status;
  assign int_hit_o  = sel_hit[0];
  assign br_hit_o   = sel_hit[1];
  assign wait_hit_o = sel_hit[2];
endmodule

// File: rtl/chanctl_regs_chk.sv
module chanctl_regs_chk
  import chanctl_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_we_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [DATA_W-1:0] bus_wdata_i,
  input logic              seq_upd_i,
  input logic [ST_W-1:0]   seq_mask_i,
  input logic [ST_W-1:0]   seq_val_i,
  input logic [ST_W-1:0]   status_o,
  input logic [DATA_W-1:0] cmdptr_o,
  input logic              start_o,
  input logic              fetch_o,
  input logic              ctrl_wr
);
  localparam int ML = DATA_W / 2;

  p_start_active_r4: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> status_o[B_ACT]);

  p_pause_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !seq_upd_i) |=> !(status_o[B_PAUSE] && status_o[B_ACT]));

  p_stop_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !seq_upd_i && status_o[B_RUN] && bus_wdata_i[ML + B_RUN] && !bus_wdata_i[B_RUN])
    |=> (!status_o[B_ACT] && !status_o[B_DEAD]));

  p_ptr_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we_i && bus_addr_i == ADDR_W'(RA_PTR) && (status_o[B_RUN] || status_o[B_ACT]))
    |=> ($stable(cmdptr_o) && !fetch_o));

  p_fetch_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_o |-> $past(bus_we_i && bus_addr_i == ADDR_W'(RA_PTR) &&
                      !status_o[B_RUN] && !status_o[B_ACT]));

  p_status_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_wr && !seq_upd_i) |=> $stable(status_o));

  p_seq_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    seq_upd_i |=> (((status_o ^ $past(seq_val_i)) & $past(seq_mask_i)) == '0));
endmodule

bind chanctl_regs chanctl_regs_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_we_i    (bus_we_i),
  .bus_addr_i  (bus_addr_i),
  .bus_wdata_i (bus_wdata_i),
  .seq_upd_i   (seq_upd_i),
  .seq_mask_i  (seq_mask_i),
  .seq_val_i   (seq_val_i),
  .status_o    (status_o),
  .cmdptr_o    (cmdptr_o),
  .start_o     (start_o),
  .fetch_o     (fetch_o),
  .ctrl_wr     (ctrl_wr)
);

// File: tb/test_chanctl_regs.sv
module test_chanctl_regs;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        seq_upd = 1'b0;
  logic [15:0] seq_mask = '0;
  logic [15:0] seq_val = '0;
  logic [15:0] status;
  logic [31:0] cmdptr;
  logic        start, fetch, int_hit, br_hit, wait_hit;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  chanctl_regs i_chanctl_regs (
    .clk(clk), .rst_n(rst_n), .bus_we_i(bus_we), .bus_addr_i(bus_addr),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .seq_upd_i(seq_upd),
    .seq_mask_i(seq_mask), .seq_val_i(seq_val), .status_o(status),
    .cmdptr_o(cmdptr), .start_o(start), .fetch_o(fetch),
    .int_hit_o(int_hit), .br_hit_o(br_hit), .wait_hit_o(wait_hit)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one cycle of bus and/or sequencer activity; returns just after the edge
  task automatic cycle(bit we, logic [2:0] a, logic [31:0] d, bit su, logic [15:0] sm, logic [15:0] sv);
    @(negedge clk);
    bus_we = we; bus_addr = a; bus_wdata = d;
    seq_upd = su; seq_mask = sm; seq_val = sv;
    @(posedge clk); #1;
    bus_we = 1'b0; seq_upd = 1'b0;
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    cycle(1'b1, a, d, 1'b0, '0, '0);
  endtask

  task automatic seq(logic [15:0] sm, logic [15:0] sv);
    cycle(1'b0, '0, '0, 1'b1, sm, sv);
  endtask

  task automatic rd_chk(string req, logic [2:0] a, logic [31:0] exp);
    bus_addr = a; #1;
    chk(req, bus_rdata, exp);
  endtask

  task automatic next_edge();
    @(posedge clk); #1;
  endtask

  task automatic t_reset();
    chk("R1 status", {16'h0, status}, 32'h0);
    chk("R1 cmdptr", cmdptr, 32'h0);
    chk("R1 pulses", {30'h0, start, fetch}, 32'h0);
    rd_chk("R1 int sel", 3'd3, 32'h0);
    rd_chk("R1 wait sel", 3'd5, 32'h0);
  endtask

  task automatic t_merge();
    wr(3'd0, 32'h000F_0005);
    chk("R2 merge all dev", {16'h0, status}, 32'h0005);
    wr(3'd0, 32'h0003_0002);
    chk("R2 merge partial", {16'h0, status}, 32'h0006);
  endtask

  task automatic t_nonwritable();
    seq(16'h0500, 16'h0500);
    chk("R10 seq sets act+bt", {16'h0, status}, 32'h0506);
    wr(3'd0, 32'h0DF0_FFFF);
    chk("R3 masked fixed bits cleared", {16'h0, status}, 32'h0006);
  endtask

  task automatic t_run_pause_stop();
    wr(3'd0, 32'h8000_8000);
    chk("R4 run sets active", {16'h0, status}, 32'h8406);
    chk("R4 start pulse", {31'h0, start}, 32'h1);
    next_edge();
    chk("R4 start single", {31'h0, start}, 32'h0);
    wr(3'd2, 32'h0000_1234);
    chk("R7 ptr locked", cmdptr, 32'h0);
    chk("R7 no fetch", {31'h0, fetch}, 32'h0);
    wr(3'd0, 32'h4000_4000);
    chk("R5 pause clears active", {16'h0, status}, 32'hC006);
    chk("R5 no start", {31'h0, start}, 32'h0);
    wr(3'd2, 32'h0000_5670);
    chk("R7 ptr locked on run only", cmdptr, 32'h0);
    wr(3'd0, 32'h4000_0000);
    chk("R4 resume sets active", {16'h0, status}, 32'h8406);
    chk("R4 resume start", {31'h0, start}, 32'h1);
    seq(16'h0800, 16'h0800);
    chk("R10 seq sets dead", {16'h0, status}, 32'h8C06);
    wr(3'd0, 32'h8000_0000);
    chk("R6 stop clears act dead", {16'h0, status}, 32'h0006);
  endtask

  task automatic t_dead_blocks();
    seq(16'h0800, 16'h0800);
    wr(3'd0, 32'h8000_8000);
    chk("R4 dead blocks active", {16'h0, status}, 32'h8806);
    chk("R4 dead no start", {31'h0, start}, 32'h0);
    wr(3'd0, 32'h8000_0000);
    chk("R6 stop clears dead", {16'h0, status}, 32'h0006);
  endtask

  task automatic t_ptr_ok();
    wr(3'd2, 32'hABCD_123F);
    chk("R8 aligned ptr", cmdptr, 32'hABCD_1230);
    chk("R8 fetch pulse", {31'h0, fetch}, 32'h1);
    next_edge();
    chk("R8 fetch single", {31'h0, fetch}, 32'h0);
    rd_chk("R12 read ptr", 3'd2, 32'hABCD_1230);
  endtask

  task automatic t_status_ro();
    wr(3'd1, 32'hFFFF_FFFF);
    chk("R9 status write ignored", {16'h0, status}, 32'h0006);
    rd_chk("R12 read status", 3'd1, 32'h0006);
    rd_chk("R12 read ctrl", 3'd0, 32'h0006);
    rd_chk("R12 unmapped", 3'd7, 32'h0);
  endtask

  task automatic t_collide();
    cycle(1'b1, 3'd0, 32'h000F_0009, 1'b1, 16'h0003, 16'h0002);
    chk("R10 seq wins bitwise", {16'h0, status}, 32'h000A);
  endtask

  task automatic t_cond();
    wr(3'd3, 32'h000C_0008);
    wr(3'd4, 32'h0003_0001);
    chk("R11 int hit", {31'h0, int_hit}, 32'h1);
    chk("R11 br miss", {31'h0, br_hit}, 32'h0);
    chk("R11 wait zero hits", {31'h0, wait_hit}, 32'h1);
    rd_chk("R11 int sel readback", 3'd3, 32'h000C_0008);
    wr(3'd4, 32'hFFFF_FFFF);
    rd_chk("R12 sel unkept bits", 3'd4, 32'h000F_000F);
    chk("R11 br full mask miss", {31'h0, br_hit}, 32'h0);
    wr(3'd0, 32'h000F_000F);
    chk("R11 br full mask hit", {31'h0, br_hit}, 32'h1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_merge();
    t_nonwritable();
    t_run_pause_stop();
    t_dead_blocks();
    t_ptr_ok();
    t_status_ro();
    t_collide();
    t_cond();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule